// File: doc/BRIEF.md
# Weighted Fair Queuing Output Scheduler

This block decides, at each transmission opportunity of an output link, which of several per-flow queues sends its next packet. Every accepted packet gets a finish tag. The tag is the larger of the current virtual time and that flow's previous finish tag, plus the packet length scaled by the inverse of the flow's weight. The scheduler then serves the queued head packet whose tag is smallest. Because of this, service order can differ from arrival order, and each backlogged flow receives a share of the link that follows its weight, whatever the other flows do.

The block does not store packet data. It keeps one small tag FIFO per flow, the last finish tag of each flow, and a virtual clock. An upstream buffer reports each arrival by flow index and length. A transmitter pulses `link_ready` when it can take a packet. One cycle later the block names the flow to send, together with that packet's tag. A weight of zero turns a flow off. Weights are read when a packet arrives.

Top module: `wfq_sched`

## Requirements
- R1: After reset `grant_valid` is 0, the virtual time is 0 and every flow's previous finish tag is 0.
- R2: An arrival is accepted when the flow's weight is nonzero and its tag FIFO (depth 4 by default) is not full. The accepted packet's tag is max(virtual time, flow's previous finish tag) + length × floor(32768 / weight). This tag becomes the flow's previous finish tag.
- R3: If `link_ready` is 1 in a cycle and any packet is queued, then in the next cycle `grant_valid` is 1. `grant_flow` then holds the flow whose head tag is smallest, and `grant_tag` holds that tag. When head tags are equal, the lowest flow index wins. The granted packet leaves its FIFO.
- R4: If `link_ready` is 1 while no packet is queued, `grant_valid` is 0 in the next cycle. `grant_valid` is also 0 in any cycle that follows a cycle with `link_ready` at 0.
- R5: Each grant sets the virtual time to the granted tag.
- R6: When a grant leaves every FIFO empty and no arrival is accepted in the same cycle, the virtual time and all previous finish tags return to 0.
- R7: An arrival for a flow whose weight is 0 is dropped and has no effect on later grants or tags.
- R8: An arrival for a flow whose FIFO already holds 4 tags is dropped and has no effect on later grants or tags.
- R9: Take two flows that stay backlogged with equal packet lengths and weights 3 and 1. Over 40 grants the first flow receives 30 ± 2 of them. This holds even when the second flow tries to add a packet several times between grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | Packet arrival notification |
| arr_flow | input | 3 | Flow index of the arriving packet |
| arr_len | input | 11 | Length of the arriving packet |
| flow_weights | input | 64 | Weight of flow i in bits [8i+7:8i]; 0 disables the flow |
| link_ready | input | 1 | Transmission opportunity |
| grant_valid | output | 1 | A flow was chosen for the last opportunity |
| grant_flow | output | 3 | Chosen flow index |
| grant_tag | output | 32 | Finish tag of the granted packet |

## Verification
The bench targets the following corner cases and the faults each would expose:
- Equal tags on two flows: a design that kept the later index on a tie would grant the wrong flow first.
- The system running dry: if the clock and previous tags were not cleared, the first tag after idling would carry an old offset and stop equalling the bare length term.
- Zero weights and full FIFOs: a design that did not drop these arrivals would produce extra grants, or tags shifted by phantom packets.
- A long randomized mix of arrivals, grants and drains, checked against an arithmetic model: a wrong max() choice, a wrong scaling or a virtual time that failed to follow the granted tag would show up as a tag mismatch.
- A flooding flow: a design that let it crowd out a heavier neighbour would break the 3:1 service count.

// File: rtl/wfq_pkg.sv
package wfq_pkg;

    localparam int RECIP_SHIFT = 15;
    localparam int RECIP_W     = 16;

    // scaled inverse of a weight; zero weight maps to zero
    function automatic logic [RECIP_W-1:0] recip_of(input int w);
        if (w == 0) begin
            return '0;
        end
        return RECIP_W'((1 << RECIP_SHIFT) / w);
    endfunction

endpackage

// File: rtl/wfq_recip.sv
module wfq_recip #(
    parameter int WGT_W = 8
) (
    input  logic [WGT_W-1:0]            weight,
    output logic [wfq_pkg::RECIP_W-1:0] recip
);
    localparam int ENTRIES = 1 << WGT_W;

    logic [wfq_pkg::RECIP_W-1:0] tab [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tab
        assign tab[g] = wfq_pkg::recip_of(g);
    end

    assign recip = tab[weight];

endmodule

// File: rtl/wfq_flow_queue.sv
module wfq_flow_queue #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic             full,
    output logic             single
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fq_state_t;

    fq_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wr] = push_tag;
            s_d.wr          = bump(s_q.wr);
        end
        if (pop) begin
            s_d.rd = bump(s_q.rd);
        end
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_tag = s_q.mem[s_q.rd];
    assign empty    = (s_q.cnt == '0);
    assign full     = (s_q.cnt == CNT_W'(DEPTH));
    assign single   = (s_q.cnt == CNT_W'(1));

    // R8: the owner never writes into a full FIFO
    assert_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt != CNT_W'(DEPTH)));

    // R3: a grant only removes a tag that exists
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));

endmodule

// File: rtl/wfq_pick.sv
module wfq_pick #(
    parameter int N     = 8,
    parameter int TAG_W = 32,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    output logic                    any,
    output logic [IDX_W-1:0]        idx,
    output logic [TAG_W-1:0]        tag
);
    // strict less-than keeps the lowest index on equal tags
    always_comb begin
        any = 1'b0;
        idx = '0;
        tag = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!any || (tags[i] < tag))) begin
                any = 1'b1;
                idx = IDX_W'(i);
                tag = tags[i];
            end
        end
    end

endmodule

// File: rtl/wfq_sched.sv
module wfq_sched #(
    parameter int NFLOWS = 8,
    parameter int WGT_W  = 8,
    parameter int LEN_W  = 11,
    parameter int TAG_W  = 32,
    parameter int QDEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arr_valid,
    input  logic [$clog2(NFLOWS)-1:0] arr_flow,
    input  logic [LEN_W-1:0]          arr_len,
    input  logic [NFLOWS*WGT_W-1:0]   flow_weights,
    input  logic                      link_ready,
    output logic                      grant_valid,
    output logic [$clog2(NFLOWS)-1:0] grant_flow,
    output logic [TAG_W-1:0]          grant_tag
);
    localparam int FID_W  = $clog2(NFLOWS);
    localparam int PROD_W = LEN_W + wfq_pkg::RECIP_W;

    typedef struct packed {
        logic [TAG_W-1:0]             vt;
        logic [NFLOWS-1:0][TAG_W-1:0] last_fin;
        logic                         gv;
        logic [FID_W-1:0]             gflow;
        logic [TAG_W-1:0]             gtag;
    } sched_state_t;

    sched_state_t s_d, s_q;

    logic [WGT_W-1:0]             arr_w;
    logic [wfq_pkg::RECIP_W-1:0]  arr_recip;
    logic [PROD_W-1:0]            arr_prod;
    logic [TAG_W-1:0]             arr_start;
    logic [TAG_W-1:0]             arr_tag;
    logic                         accept;

    logic [NFLOWS-1:0]            push;
    logic [NFLOWS-1:0]            pop;
    logic [NFLOWS-1:0]            q_empty;
    logic [NFLOWS-1:0]            q_full;
    logic [NFLOWS-1:0]            q_single;
    logic [NFLOWS-1:0]            busy_after;
    logic [NFLOWS-1:0][TAG_W-1:0] q_head;

    logic                         pick_any;
    logic [FID_W-1:0]             pick_idx;
    logic [TAG_W-1:0]             pick_tag;
    logic                         serve;

    // tag arithmetic for the arriving packet
    assign arr_w = flow_weights[int'(arr_flow)*WGT_W +: WGT_W];

    wfq_recip #(.WGT_W(WGT_W)) u_recip (
        .weight (arr_w),
        .recip  (arr_recip)
    );

    assign arr_prod  = {{wfq_pkg::RECIP_W{1'b0}}, arr_len} * {{LEN_W{1'b0}}, arr_recip};
    assign arr_start = (s_q.last_fin[arr_flow] > s_q.vt) ? s_q.last_fin[arr_flow] : s_q.vt;
    assign arr_tag   = arr_start + TAG_W'(arr_prod);
    assign accept    = arr_valid && (arr_w != '0) && !q_full[arr_flow];

    // per-flow tag storage
    for (genvar f = 0; f < NFLOWS; f++) begin : g_flow
        assign push[f] = accept && (arr_flow == FID_W'(f));
        assign pop[f]  = serve && (pick_idx == FID_W'(f));
        assign busy_after[f] = push[f] || (!q_empty[f] && !(pop[f] && q_single[f]));

        wfq_flow_queue #(.DEPTH(QDEPTH), .TAG_W(TAG_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[f]),
            .push_tag (arr_tag),
            .pop      (pop[f]),
            .head_tag (q_head[f]),
            .empty    (q_empty[f]),
            .full     (q_full[f]),
            .single   (q_single[f])
        );
    end

    wfq_pick #(.N(NFLOWS), .TAG_W(TAG_W), .IDX_W(FID_W)) u_pick (
        .valid (~q_empty),
        .tags  (q_head),
        .any   (pick_any),
        .idx   (pick_idx),
        .tag   (pick_tag)
    );

    assign serve = link_ready && pick_any;

    always_comb begin
        s_d    = s_q;
        s_d.gv = 1'b0;
        if (accept) begin
            s_d.last_fin[arr_flow] = arr_tag;
        end
        if (serve) begin
            s_d.vt    = pick_tag;
            s_d.gv    = 1'b1;
            s_d.gflow = pick_idx;
            s_d.gtag  = pick_tag;
        end
        if (busy_after == '0) begin
            s_d.vt       = '0;
            s_d.last_fin = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_valid = s_q.gv;
    assign grant_flow  = s_q.gflow;
    assign grant_tag   = s_q.gtag;

    // R3: a grant is always answering an opportunity of the previous cycle
    assert_grant_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(link_ready));

    // R3: at most one FIFO gives up a tag per cycle
    assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    // R2: at most one FIFO takes a tag per cycle
    assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));

    // R5: virtual time never moves backwards except when cleared
    assert_vt_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.vt != '0) |-> (s_q.vt >= $past(s_q.vt)));

    // R6: with every FIFO empty the virtual clock sits at zero
    assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty == '1) |-> (s_q.vt == '0));

endmodule

// File: tb/wfq_sched_test.sv
module wfq_sched_test;
    localparam int NF = 8;
    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arr_valid = 1'b0;
    logic [2:0]  arr_flow = '0;
    logic [10:0] arr_len = '0;
    logic [63:0] flow_weights = '0;
    logic        link_ready = 1'b0;
    logic        grant_valid;
    logic [2:0]  grant_flow;
    logic [31:0] grant_tag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    longint m_vt;
    longint m_last [NF];
    longint m_q    [NF][QD];
    int     m_cnt  [NF];
    int     wts    [NF];
    int     last_served;
    int     seed = 12345;

    always #5 clk = ~clk;

    wfq_sched uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .arr_valid    (arr_valid),
        .arr_flow     (arr_flow),
        .arr_len      (arr_len),
        .flow_weights (flow_weights),
        .link_ready   (link_ready),
        .grant_valid  (grant_valid),
        .grant_flow   (grant_flow),
        .grant_tag    (grant_tag)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_w(input int f, input int w);
        wts[f] = w;
        flow_weights[f*8 +: 8] = 8'(w);
    endtask

    function automatic int model_total();
        int s = 0;
        for (int i = 0; i < NF; i++) s += m_cnt[i];
        return s;
    endfunction

    task automatic model_clear();
        m_vt = 0;
        for (int i = 0; i < NF; i++) begin
            m_last[i] = 0;
            m_cnt[i]  = 0;
        end
    endtask

    // R2 R7 R8: model of tag assignment and drops
    task automatic arrive(input int f, input int len);
        @(negedge clk);
        arr_valid = 1'b1;
        arr_flow  = 3'(f);
        arr_len   = 11'(len);
        @(posedge clk);
        #2;
        arr_valid = 1'b0;
        if (wts[f] != 0 && m_cnt[f] < QD) begin
            longint st = (m_last[f] > m_vt) ? m_last[f] : m_vt;
            longint tg = st + longint'(len) * longint'(32768 / wts[f]);
            m_q[f][m_cnt[f]] = tg;
            m_cnt[f]++;
            m_last[f] = tg;
        end
    endtask

    // R3 R4 R5 R6: one opportunity, compared against the model
    task automatic serve(input string req);
        int     bf = -1;
        longint bt = 0;
        for (int i = 0; i < NF; i++) begin
            if (m_cnt[i] > 0 && (bf < 0 || m_q[i][0] < bt)) begin
                bf = i;
                bt = m_q[i][0];
            end
        end
        @(negedge clk);
        link_ready = 1'b1;
        @(posedge clk);
        #2;
        link_ready = 1'b0;
        last_served = int'(grant_flow);
        if (bf < 0) begin
            chk(grant_valid == 1'b0, {req, " R4 idle grant"}, grant_valid, 0);
        end else begin
            chk(grant_valid == 1'b1, {req, " R3 valid"}, grant_valid, 1);
            chk(int'(grant_flow) == bf, {req, " R3 flow"}, grant_flow, bf);
            chk(longint'(grant_tag) == bt, {req, " R2 R5 tag"}, grant_tag, bt);
            for (int k = 0; k < QD - 1; k++) m_q[bf][k] = m_q[bf][k+1];
            m_cnt[bf]--;
            m_vt = bt;
            if (model_total() == 0) model_clear();
        end
    endtask

    task automatic drain(input string req);
        while (model_total() > 0) serve(req);
        serve({req, " drained"});
    endtask

    function automatic int rnd(input int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 32'h7fffff) % m;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n0;
        model_clear();
        for (int i = 0; i < NF; i++) set_w(i, 0);
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        // R1: nothing granted out of reset
        chk(grant_valid == 1'b0, "R1 reset grant", grant_valid, 0);
        serve("R1 R4 empty opportunity");

        // R1 R2: first tag starts from zero virtual time
        set_w(1, 4);
        arrive(1, 64);
        serve("R1 R2 first tag");

        // R3: equal tags, lowest index wins
        set_w(5, 2);
        set_w(2, 2);
        arrive(5, 100);
        arrive(2, 100);
        serve("R3 tie");
        serve("R3 tie second");
        drain("R6 after tie");

        // R6: tags restart from zero after idling
        arrive(2, 100);
        serve("R6 restart tag");

        // R7: zero-weight flow is ignored
        set_w(7, 0);
        arrive(7, 500);
        serve("R7 zero weight");

        // R8: fifth packet on a full FIFO is dropped
        set_w(3, 5);
        for (int k = 0; k < 5; k++) arrive(3, 200 + k);
        drain("R8 full FIFO");

        // R3: out-of-order service by tag
        set_w(0, 1);
        set_w(4, 200);
        arrive(0, 300);
        arrive(4, 300);
        arrive(4, 300);
        serve("R3 reorder");
        serve("R3 reorder");
        drain("R3 reorder");

        // R9: weights 3:1, flow 1 floods between grants
        set_w(0, 3);
        set_w(1, 1);
        for (int k = 0; k < QD; k++) begin
            arrive(0, 100);
            arrive(1, 100);
        end
        n0 = 0;
        for (int k = 0; k < 40; k++) begin
            serve("R9 share");
            if (last_served == 0) n0++;
            if (last_served == 0) arrive(0, 100);
            arrive(1, 100);
            arrive(1, 100);
            arrive(1, 100);
        end
        chk(n0 >= 28 && n0 <= 32, "R9 weighted share", n0, 30);
        drain("R9 drain");

        // R2 R3 R5 R6 R7 R8: long randomized sweep
        for (int i = 0; i < 7; i++) set_w(i, 1 + rnd(255));
        set_w(7, 0);
        for (int it = 0; it < 900; it++) begin
            int op = rnd(3);
            if (op < 2) arrive(rnd(NF), rnd(2048));
            else        serve("sweep R3");
            if (it % 30 == 29) begin
                drain("sweep R6");
                if (it % 90 == 89) begin
                    for (int i = 0; i < 7; i++) set_w(i, 1 + rnd(255));
                end
            end
        end
        drain("final");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule